// File: doc/BRIEF.md
# PCI I/O Window Remapper

This block sits on the CPU side of a PCI host bridge and turns CPU accesses that fall into the bridge's I/O window into single transactions on the bridge's internal PCI I/O space. A level input picks one of two translations for each access. The dense translation keeps the low 16 bits of the window offset, so the window behaves as a 64 KB port space. The sparse translation spreads the 64 KB port space across the whole 8 MB window. It keeps the five lowest offset bits and moves the 4 KB page number down by seven bit positions, which places each 32-byte port group on its own page.

A request carries an address, a byte count of 1, 2 or 4, write data and a write flag. The block accepts any alignment. It puts the data on an eight-lane little-endian byte bus so that each byte lands on the lane of its own address. It also produces a matching byte-enable mask and a word-aligned downstream address. The transaction appears one cycle after the request. A request with any other byte count produces a one-cycle error pulse and no transaction. Requests outside the window are dropped.

Top module: `pio_window_remap`

## Requirements
- R1: While rst_ni is low and after its release with no request, io_valid_o and err_o are 0.
- R2: A request is handled only when req_addr_i lies in [0x8000_0000, 0x8080_0000). Any other address gives neither io_valid_o nor err_o.
- R3: With mode_i = 0, the downstream byte address is 0x8000_0000 + (off & 0xFFFF), where off = req_addr_i - 0x8000_0000. io_addr_o carries that address with its two low bits cleared.
- R4: With mode_i = 1, the downstream byte address is 0x8000_0000 + ((off & 0x1F) | ((off & 0x7F_F000) >> 7)). io_addr_o carries that address with its two low bits cleared.
- R5: mode_i is sampled in the same cycle as the request. A change between two back-to-back requests applies to the second one.
- R6: For a legal byte count n, io_be_o[7:0] = ((1 << n) - 1) << off[1:0]. Bit k enables the byte at io_addr_o + k.
- R7: io_wdata_o[63:0] = (req_wdata_i & low 8n bits) << (8 * off[1:0]). Lanes that are not enabled read 0.
- R8: A byte count other than 1, 2 or 4 inside the window raises err_o for exactly one cycle and leaves io_valid_o at 0.
- R9: A handled request shows on the outputs in the cycle after the one where req_valid_i is sampled. With no request, io_valid_o returns to 0.
- R10: io_we_o equals the request's req_we_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects the dense map, 1 selects the sparse map |
| req_valid_i | input | 1 | CPU request present this cycle |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 32 | CPU byte address |
| req_size_i | input | 3 | Byte count; 1, 2 and 4 are legal |
| req_wdata_i | input | 32 | Write data, little-endian, right-justified |
| io_valid_o | output | 1 | Downstream transaction valid |
| io_we_o | output | 1 | Downstream write flag |
| io_addr_o | output | 32 | Word-aligned downstream address |
| io_be_o | output | 8 | Byte enables over two words |
| io_wdata_o | output | 64 | Lane-aligned write data |
| err_o | output | 1 | One-cycle illegal-size pulse |

## Verification
The hardest case to reach from the ports is a mode flip between two back-to-back requests, because the two requests must use different maps with no idle cycle between them. The stimulus holds req_valid_i high across consecutive cycles and toggles mode_i on every request of a long sweep. A stale or delayed mode sample would therefore send an address through the wrong map. The same sweep covers offsets in all four byte positions with every legal size, so 4-byte accesses that cross into the second word are exercised.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_BAD} sz_e;

  function automatic sz_e size_decode(input logic [2:0] n);
    case (n)
      3'd1:    return SZ_B;
      3'd2:    return SZ_H;
      3'd4:    return SZ_W;
      default: return SZ_BAD;
    endcase
  endfunction
endpackage

// File: rtl/pio_addr_map.sv
module pio_addr_map #(
  parameter int ADDR_W     = 32,
  parameter int WIN_LOG2   = 23,
  parameter int DENSE_BITS = 16,
  parameter int KEEP_LOW   = 5,
  parameter int PAGE_SHIFT = 12,
  parameter int PAGE_DROP  = 7
) (
  input  logic [WIN_LOG2-1:0] off_i,
  input  logic                sparse_i,
  output logic [ADDR_W-1:0]   map_o
);
  localparam int PAGE_W = WIN_LOG2 - PAGE_SHIFT;
  localparam int DST_LO = PAGE_SHIFT - PAGE_DROP;

  logic [ADDR_W-1:0] dense, sparse;

  always_comb begin
    dense  = '0;
    dense[DENSE_BITS-1:0] = off_i[DENSE_BITS-1:0];
    sparse = '0;
    sparse[KEEP_LOW-1:0] = off_i[KEEP_LOW-1:0];
    sparse[DST_LO +: PAGE_W] = sparse[DST_LO +: PAGE_W] | off_i[PAGE_SHIFT +: PAGE_W];
    map_o = sparse_i ? sparse : dense;
  end
endmodule

// File: rtl/pio_lane_pack.sv
module pio_lane_pack
  import pio_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  sz_e                 size_i,
  input  logic [LANE_W-1:0]   lane_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*LANES-1:0]  be_o,
  output logic [2*DATA_W-1:0] data_o
);
  logic [LANES-1:0]  keep;
  logic [DATA_W-1:0] masked;

  always_comb begin
    case (size_i)
      SZ_B:    keep = LANES'(1);
      SZ_H:    keep = LANES'(3);
      SZ_W:    keep = '1;
      default: keep = '0;
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign masked[k*8 +: 8] = keep[k] ? wdata_i[k*8 +: 8] : 8'h00;
  end

  assign be_o   = {LANES'(0), keep} << lane_i;
  assign data_o = {DATA_W'(0), masked} << (8 * lane_i);
endmodule

// File: rtl/pio_window_remap.sv
module pio_window_remap
  import pio_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int          WIN_LOG2   = 23,
  parameter int          DENSE_BITS = 16,
  parameter int          KEEP_LOW   = 5,
  parameter int          PAGE_SHIFT = 12,
  parameter int          PAGE_DROP  = 7,
  parameter logic [31:0] IO_BASE    = 32'h8000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2:0]          req_size_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                io_valid_o,
  output logic                io_we_o,
  output logic [ADDR_W-1:0]   io_addr_o,
  output logic [DATA_W/4-1:0] io_be_o,
  output logic [2*DATA_W-1:0] io_wdata_o,
  output logic                err_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int TAG_W  = ADDR_W - WIN_LOG2;

  sz_e                 size;
  logic                hit;
  logic [ADDR_W-1:0]   mapped, dst;
  logic [2*LANES-1:0]  be_n;
  logic [2*DATA_W-1:0] data_n;

  assign size = size_decode(req_size_i);
  assign hit  = req_valid_i && (req_addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);

  pio_addr_map #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .DENSE_BITS(DENSE_BITS),
    .KEEP_LOW(KEEP_LOW), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_DROP(PAGE_DROP)
  ) u_map (
    .off_i   (req_addr_i[WIN_LOG2-1:0]),
    .sparse_i(mode_i),
    .map_o   (mapped)
  );

  pio_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .size_i (size),
    .lane_i (req_addr_i[LANE_W-1:0]),
    .wdata_i(req_wdata_i),
    .be_o   (be_n),
    .data_o (data_n)
  );

  assign dst = IO_BASE[ADDR_W-1:0] + mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_valid_o <= 1'b0;
      io_we_o    <= 1'b0;
      io_addr_o  <= '0;
      io_be_o    <= '0;
      io_wdata_o <= '0;
      err_o      <= 1'b0;
    end else begin
      io_valid_o <= hit && (size != SZ_BAD);
      err_o      <= hit && (size == SZ_BAD);
      if (hit && size != SZ_BAD) begin
        io_we_o    <= req_we_i;
        io_addr_o  <= {dst[ADDR_W-1:LANE_W], LANE_W'(0)};
        io_be_o    <= be_n;
        io_wdata_o <= data_n;
      end
    end
  end

  AST_ERR_NO_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !io_valid_o); // R8
  AST_BE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o |-> ($countones(io_be_o) == 1 || $countones(io_be_o) == 2 ||
                    $countones(io_be_o) == LANES)); // R6
  AST_TXN_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o |-> $past(req_valid_i)); // R9
  AST_WE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o |-> io_we_o == $past(req_we_i)); // R10
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o |-> io_addr_o[LANE_W-1:0] == '0); // R3
  AST_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_o || err_o) |-> $past(req_addr_i[ADDR_W-1:WIN_LOG2]) == WIN_BASE[ADDR_W-1:WIN_LOG2]); // R2
  AST_PORT_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o |-> io_addr_o[ADDR_W-1:DENSE_BITS] == IO_BASE[ADDR_W-1:DENSE_BITS]); // R4

  logic unused_tag;
  assign unused_tag = ^TAG_W;
endmodule

// File: tb/sim_pio_window_remap.sv
module sim_pio_window_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, rv = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wd = '0;
  logic [2:0]  sz = 3'd1;
  logic        io_valid, io_we, err;
  logic [31:0] io_addr;
  logic [7:0]  io_be;
  logic [63:0] io_wdata;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pio_window_remap u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .req_valid_i(rv), .req_we_i(we),
    .req_addr_i(addr), .req_size_i(sz), .req_wdata_i(wd),
    .io_valid_o(io_valid), .io_we_o(io_we), .io_addr_o(io_addr), .io_be_o(io_be),
    .io_wdata_o(io_wdata), .err_o(err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic m);
    logic [31:0] off, e;
    off = a - 32'h8000_0000;
    e = m ? ((off & 32'h1F) | ((off & 32'h007F_F000) >> 7)) : (off & 32'hFFFF);
    return (32'h8000_0000 + e) & ~32'h3;
  endfunction

  // Expects outputs one cycle after the request driven at the previous negedge.
  task automatic req_chk(input logic m, input logic w, input logic [31:0] a,
                         input logic [2:0] n, input logic [31:0] d);
    logic        in_win, legal;
    logic [7:0]  ebe;
    logic [63:0] edata, dmask;
    mode = m; we = w; addr = a; sz = n; wd = d; rv = 1'b1;
    @(negedge clk);
    in_win = (a[31:23] == 9'h100);
    legal  = (n == 3'd1 || n == 3'd2 || n == 3'd4);
    if (!in_win) begin
      check("R2 valid", {63'd0, io_valid}, 64'd0);
      check("R2 err", {63'd0, err}, 64'd0);
    end else if (!legal) begin
      check("R8 err", {63'd0, err}, 64'd1);
      check("R8 valid", {63'd0, io_valid}, 64'd0);
    end else begin
      ebe   = 8'(((16'd1 << n) - 16'd1) << a[1:0]);
      dmask = (64'd1 << (8 * n)) - 64'd1;
      edata = ({32'd0, d} & dmask) << (8 * a[1:0]);
      check("R9 valid", {63'd0, io_valid}, 64'd1);
      check(m ? "R4 R5 addr" : "R3 R5 addr", {32'd0, io_addr}, {32'd0, exp_addr(a, m)});
      check("R6 be", {56'd0, io_be}, {56'd0, ebe});
      check("R7 data", io_wdata, edata);
      check("R10 we", {63'd0, io_we}, {63'd0, w});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, io_valid}, 64'd0);
    check("R1 err in reset", {63'd0, err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid idle", {63'd0, io_valid}, 64'd0);
    // sweep: mode toggles each back-to-back request (R5)
    for (int i = 0; i < 600; i++) begin
      logic [31:0] off;
      logic [2:0]  n;
      off = (i * 32'h0001_3579 + i * i * 32'd7 + 32'(i % 4)) & 32'h007F_FFFF;
      n = (i % 3 == 0) ? 3'd1 : ((i % 3 == 1) ? 3'd2 : 3'd4);
      req_chk(i[0], i[1], 32'h8000_0000 + off, n, 32'hA5C3_0000 ^ (i * 32'h0101_0F1B));
    end
    // window edges and corners
    req_chk(1'b1, 1'b1, 32'h807F_FFFF, 3'd4, 32'h1122_3344);
    req_chk(1'b0, 1'b1, 32'h807F_FFFD, 3'd4, 32'hDEAD_BEEF);
    req_chk(1'b1, 1'b0, 32'h8000_0003, 3'd2, 32'hFFFF_FFFF);
    req_chk(1'b0, 1'b1, 32'h8000_0000, 3'd1, 32'hFFFF_FF7E);
    req_chk(1'b0, 1'b1, 32'h7FFF_FFFC, 3'd4, 32'h0);
    req_chk(1'b1, 1'b1, 32'h8080_0000, 3'd4, 32'h0);
    req_chk(1'b0, 1'b1, 32'hC000_0000, 3'd1, 32'h0);
    // every illegal count, then a legal one right after (error lasts one cycle)
    for (int n = 0; n < 8; n++) begin
      req_chk(n[0], 1'b1, 32'h8000_1234 + 32'(n), 3'(n), 32'h5A5A_5A5A);
    end
    req_chk(1'b0, 1'b1, 32'h8000_0CF8, 3'd4, 32'h8000_0000);
    check("R8 err cleared", {63'd0, err}, 64'd0);
    rv = 1'b0;
    @(negedge clk);
    check("R9 idle after burst", {63'd0, io_valid}, 64'd0);
    check("R8 no err idle", {63'd0, err}, 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule